// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block turns an active-low external interrupt pin into an interrupt request for a small CPU core. The pin first passes through a synchronizer. A falling edge of the synchronized pin sets a request latch. A mode option, captured while reset is held, can also add a level term. In that mode the request stays active for as long as the pin is low, so several open-drain sources can share one wire without losing a request.

The CPU reports each instruction boundary with `insn_done`. The block raises `irq_take` only at a boundary, and only when a request may be served. An external request is blocked while the CPU mask bit is set, but its latch keeps its state. A software-interrupt strobe sets its own latch, and the mask bit does not affect it. When both kinds are pending at the same boundary, the software request is served first. `irq_src` tells the CPU which vector to fetch. The vector-fetch acknowledge clears the latch of the source that was served, so an edge that arrives during the service routine is taken once the mask clears again.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge on `irq_pin_n` (previous synchronized sample 1, current sample 0) sets the external request latch. The latch is visible to `irq_take` no later than the third rising clock edge after the pin falls.
- R2: With `level_mode_cfg` = 0 (edge only), a pin held low after its latch has been cleared produces no new request. With `level_mode_cfg` = 1, a low synchronized pin requests by itself, even when the latch is clear.
- R3: `irq_take` is 1 only in a cycle where `insn_done` is 1.
- R4: While `mask_i` is 1, no external request is taken, and the external latch keeps its state. The held request is taken at the first boundary after `mask_i` returns to 0.
- R5: A `vec_fetch` pulse after a take clears the latch of the source that was served. A falling edge detected in the same cycle keeps the external latch set.
- R6: A new falling edge during the service routine sets the external latch again. That request is taken at the first boundary with `mask_i` = 0.
- R7: A one-cycle `swi_strobe` sets a software request, which is taken at the next boundary whatever the value of `mask_i`.
- R8: `irq_src` is 1 for the software source and 0 for the external source. When both are pending, software is taken first and the external request stays pending.
- R9: `level_mode_cfg` is captured only while `rst_n` is low. Changing it during operation has no effect.
- R10: Reset clears both request latches, and no take is reported while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low external interrupt pin |
| level_mode_cfg | input | 1 | 1 = edge plus low level, 0 = edge only; sampled in reset |
| mask_i | input | 1 | CPU interrupt mask bit, 1 = external requests blocked |
| insn_done | input | 1 | Current instruction completes this cycle |
| swi_strobe | input | 1 | Software-interrupt request pulse, not maskable |
| vec_fetch | input | 1 | Vector-fetch acknowledge from the CPU |
| irq_take | output | 1 | Start the interrupt sequence at this boundary |
| irq_src | output | 1 | Vector select: 1 = software, 0 = external |

## Verification
The external path is driven with a single falling edge, with a pin held low across an acknowledge, and with an edge that arrives while the mask is set. Comparing the edge-only and level modes on the same held-low pin separates the latch term from the level term. The mask is toggled around a pending edge, which shows that the mask blocks the request without clearing the latch. Software strobes are issued with the mask set, and together with a pending external edge. The order of the two takes shows the priority, and also shows that the acknowledge clears only the source that was served.

// File: rtl/irq_pkg.sv
// Package: shared types for the external interrupt conditioner.
// Assumes a single-bit vector select between two sources.
package irq_pkg;
    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_SWI = 1'b1
    } irq_src_e;
endpackage

// File: rtl/irq_pin_sync.sv
// Module: synchronizes an asynchronous active-low pin and flags falling edges.
// Assumes the pin idles high; reset loads ones so no false edge appears.
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_sync,
    output logic fall_det
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
    end

    // Hold the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign pin_sync = chain_q[STAGES-1];
    assign fall_det = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/irq_req_latch.sv
// Module: a set/clear request latch. Set has priority over clear.
// Assumes set and clear are single-cycle synchronous strobes.
module irq_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Hold the request until cleared; a same-cycle set is not lost.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end
endmodule

// File: rtl/irq_boundary_arb.sv
// Module: decides at an instruction boundary whether to take an interrupt,
// picks the source (software first) and routes the vector-fetch clear back
// to the served source. Assumes one vec_fetch follows each take.
module irq_boundary_arb
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     insn_done,
    input  logic     mask_i,
    input  logic     swi_pend,
    input  logic     ext_req,
    input  logic     vec_fetch,
    output logic     take_o,
    output irq_src_e src_o,
    output logic     clr_ext,
    output logic     clr_swi
);
    logic     served_v_q;
    irq_src_e served_q;
    logic     ext_ok;

    // Combine the boundary, the mask and the priority into a take decision.
    always_comb begin
        ext_ok = ext_req & ~mask_i;
        take_o = insn_done & (swi_pend | ext_ok);
        src_o  = swi_pend ? SRC_SWI : SRC_EXT;
    end

    // Remember which source is being served until the vector fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            served_v_q <= 1'b0;
            served_q   <= SRC_EXT;
        end else if (take_o) begin
            served_v_q <= 1'b1;
            served_q   <= src_o;
        end else if (vec_fetch) begin
            served_v_q <= 1'b0;
        end
    end

    assign clr_ext = vec_fetch & served_v_q & (served_q == SRC_EXT);
    assign clr_swi = vec_fetch & served_v_q & (served_q == SRC_SWI);
endmodule

// File: rtl/ext_irq_ctrl.sv
// Module: top of the external interrupt conditioner. Synchronizes the pin,
// latches falling edges, adds an optional low-level term and arbitrates with
// a software request at instruction boundaries.
// Assumes the mode option is stable while rst_n is low.
module ext_irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pin_n,
    input  logic level_mode_cfg,
    input  logic mask_i,
    input  logic insn_done,
    input  logic swi_strobe,
    input  logic vec_fetch,
    output logic irq_take,
    output logic irq_src
);
    logic     pin_sync, fall_det;
    logic     ext_latch, swi_pend, ext_req;
    logic     clr_ext, clr_swi;
    logic     mode_q;
    irq_src_e src_sel;

    // Capture the trigger mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= level_mode_cfg;
    end

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n),
        .pin_sync(pin_sync), .fall_det(fall_det)
    );

    irq_req_latch u_ext_latch (
        .clk(clk), .rst_n(rst_n), .set_i(fall_det),
        .clr_i(clr_ext), .pend_o(ext_latch)
    );

    irq_req_latch u_swi_latch (
        .clk(clk), .rst_n(rst_n), .set_i(swi_strobe),
        .clr_i(clr_swi), .pend_o(swi_pend)
    );

    // Merge the edge latch with the optional low-level term.
    always_comb ext_req = ext_latch | (mode_q & ~pin_sync);

    irq_boundary_arb u_arb (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .mask_i(mask_i),
        .swi_pend(swi_pend), .ext_req(ext_req), .vec_fetch(vec_fetch),
        .take_o(irq_take), .src_o(src_sel),
        .clr_ext(clr_ext), .clr_swi(clr_swi)
    );

    assign irq_src = src_sel;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt conditioner, bound to the top.
module ext_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic insn_done,
    input logic mask_i,
    input logic irq_take,
    input logic irq_src,
    input logic fall_det,
    input logic ext_latch,
    input logic swi_pend,
    input logic clr_ext,
    input logic mode_q
);
    AST_EDGE_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fall_det |=> ext_latch);                                        // R1
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> insn_done);                                        // R3
    AST_MASK_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !irq_src) |-> !mask_i);                            // R4
    AST_ACK_CLEARS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ext && !fall_det) |=> !ext_latch);                         // R5
    AST_SWI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && swi_pend) |-> irq_src);                            // R8
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));                                      // R9
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .mask_i(mask_i),
    .irq_take(irq_take), .irq_src(irq_src), .fall_det(fall_det),
    .ext_latch(ext_latch), .swi_pend(swi_pend), .clr_ext(clr_ext),
    .mode_q(mode_q)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_pin_n = 1'b1;
    logic level_mode_cfg = 1'b0;
    logic mask_i = 1'b0;
    logic insn_done = 1'b0;
    logic swi_strobe = 1'b0;
    logic vec_fetch = 1'b0;
    logic irq_take, irq_src;

    int n_run = 0, n_fail = 0;

    typedef struct { logic take; logic src; string tag; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
        .level_mode_cfg(level_mode_cfg), .mask_i(mask_i),
        .insn_done(insn_done), .swi_strobe(swi_strobe),
        .vec_fetch(vec_fetch), .irq_take(irq_take), .irq_src(irq_src)
    );

    // Monitor: at every boundary, pop one expected item and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (insn_done) begin
                exp_t e;
                n_run++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL boundary with no expected item: take=%0b", irq_take);
                end else begin
                    e = exp_q.pop_front();
                    if (irq_take !== e.take || (e.take && irq_src !== e.src)) begin
                        n_fail++;
                        $display("FAIL %s: take=%0b src=%0b expected take=%0b src=%0b",
                                 e.tag, irq_take, irq_src, e.take, e.src);
                    end
                end
            end
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Driver: one-cycle boundary with an expected outcome pushed first.
    task automatic boundary(logic t, logic s, string tag);
        exp_t e;
        e.take = t; e.src = s; e.tag = tag;
        exp_q.push_back(e);
        insn_done = 1'b1;
        cyc(1);
        insn_done = 1'b0;
    endtask

    task automatic ack();
        vec_fetch = 1'b1;
        cyc(1);
        vec_fetch = 1'b0;
    endtask

    task automatic do_reset(logic mode);
        rst_n = 1'b0;
        level_mode_cfg = mode;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_pin();
        irq_pin_n = 1'b0;
        cyc(4);
        irq_pin_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        cyc(1);
        // R10: boundary during reset with a strobe gives no take
        swi_strobe = 1'b1;
        boundary(1'b0, 1'b0, "R10 no take in reset");
        swi_strobe = 1'b0;
        do_reset(1'b0);
        boundary(1'b0, 1'b0, "R10 latches clear after reset");

        // R1: single falling edge is taken, source code 0
        pulse_pin();
        n_run++;
        if (irq_take !== 1'b0) begin
            n_fail++;
            $display("FAIL R3 take off boundary: take=%0b expected 0", irq_take);
        end
        boundary(1'b1, 1'b0, "R1 edge taken");
        ack();
        boundary(1'b0, 1'b0, "R5 cleared by vector fetch");

        // R4: mask blocks, latch retained
        mask_i = 1'b1;
        pulse_pin();
        boundary(1'b0, 1'b0, "R4 masked");
        boundary(1'b0, 1'b0, "R4 masked again");
        mask_i = 1'b0;
        boundary(1'b1, 1'b0, "R4 held request taken");
        // R6: new edge during service routine (mask set)
        mask_i = 1'b1;
        ack();
        pulse_pin();
        boundary(1'b0, 1'b0, "R6 masked in service");
        mask_i = 1'b0;
        boundary(1'b1, 1'b0, "R6 re-armed request");
        ack();

        // R2 edge mode: held low pin not re-requested after clear
        irq_pin_n = 1'b0;
        cyc(4);
        boundary(1'b1, 1'b0, "R2 edge with held pin");
        ack();
        boundary(1'b0, 1'b0, "R2 edge mode held low ignored");
        irq_pin_n = 1'b1;
        cyc(3);

        // R7: software request ignores mask
        mask_i = 1'b1;
        swi_strobe = 1'b1; cyc(1); swi_strobe = 1'b0;
        boundary(1'b1, 1'b1, "R7 swi with mask set");
        ack();
        boundary(1'b0, 1'b0, "R7 swi cleared");
        mask_i = 1'b0;

        // R8: both pending, software first, external kept
        pulse_pin();
        swi_strobe = 1'b1; cyc(1); swi_strobe = 1'b0;
        boundary(1'b1, 1'b1, "R8 swi wins");
        ack();
        boundary(1'b1, 1'b0, "R8 external kept");
        ack();
        boundary(1'b0, 1'b0, "R8 all served");

        // R2/R9 level mode captured in reset, cfg changed afterwards
        do_reset(1'b1);
        level_mode_cfg = 1'b0;
        irq_pin_n = 1'b0;
        cyc(4);
        boundary(1'b1, 1'b0, "R2 level first take");
        ack();
        boundary(1'b1, 1'b0, "R9 level kept despite cfg change");
        ack();
        irq_pin_n = 1'b1;
        cyc(3);
        boundary(1'b0, 1'b0, "R2 level released");

        cyc(2);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule